// File: doc/BRIEF.md
# Fractional UART Baud Clock Generator

This block produces the timing enables for a 16550-style serial port from one fixed reference clock. The default reference is 133,333,333 Hz. A phase accumulator scales the reference by a programmable ratio, multiplier over divisor, with both values 24 bits wide. The result is an oversample enable, a one-cycle pulse at the rate of the intermediate UART clock. A prescaler then counts these oversample pulses and gives one baud enable per prescaler period. The usual prescaler period is 16. A period of 1 is used when the intermediate clock already runs at the bit rate.

Software programs three registers over a simple byte-addressed write bus and can read them back. The shifter, the FIFOs and the line control logic sit outside this block and only consume the two enables.

Top module: `fbaud_gen`

## Requirements
- R1: After reset, the multiplier reads 1, the divisor reads 1 and the prescaler reads 16.
- R2: The prescaler is at byte address 0x30 and holds the low 8 data bits. The multiplier is at 0x34 and the divisor is at 0x38, each holding 24 data bits. A write to any other address changes no register. A read of any other address returns 0.
- R3: With a legal ratio M/D and the accumulator at zero, `os_tick` is high in exactly floor(n*M/D) of the n cycles that follow the write making the ratio legal. The first of those cycles is the one right after the write edge.
- R4: When M equals D, `os_tick` is high on every cycle.
- R5: A ratio with M greater than D, or with D equal to 0, is illegal. While the ratio is illegal, no `os_tick` and no `baud_tick` appear, and the accumulator is held at zero.
- R6: `baud_tick` pulses once per P oversample pulses, where P is the prescaler value. It rises in the cycle after the oversample pulse that completes the period.
- R7: A prescaler value of 0 behaves as 1. With P equal to 1, every oversample pulse gives a baud pulse.
- R8: A write to the prescaler restarts its count. With `os_tick` high every cycle and P=4, the first `baud_tick` after the write comes 4 cycles after the write edge.
- R9: `baud_tick` is a single-cycle pulse and is only ever high in the cycle after an `os_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for both reads and writes |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr`, combinational |
| os_tick | output | 1 | Oversample enable, one reference cycle wide |
| baud_tick | output | 1 | Bit-rate enable, one reference cycle wide |

## Verification
A register write takes effect at the edge where it is sampled. The ratio engine first uses the new value one edge later, so `os_tick` responds in the cycle after the write edge. `baud_tick` follows the `os_tick` that completes a period by one more register stage. Each measurement first parks the ratio in the illegal state to clear the accumulator, then makes it legal with the final divisor write. The bench counts `os_tick` over the n cycles after that write, and counts `baud_tick` over the same window shifted by one cycle. All samples are taken at the falling edge, and read-back values are taken combinationally with the write strobe low.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam logic [7:0]  OFS_PRESC   = 8'h30;
  localparam logic [7:0]  OFS_MULT    = 8'h34;
  localparam logic [7:0]  OFS_DIVR    = 8'h38;
  localparam int unsigned RST_MULT    = 1;
  localparam int unsigned RST_DIVR    = 1;
  localparam int unsigned RST_PRESC   = 16;
endpackage

// File: rtl/fbaud_regs.sv
module fbaud_regs #(
  parameter int unsigned RATIO_W = 24,
  parameter int unsigned PS_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [fbaud_pkg::ADDR_W-1:0] bus_addr,
  input  logic [RATIO_W-1:0]          bus_wdata,
  output logic [RATIO_W-1:0]          bus_rdata,
  output logic [RATIO_W-1:0]          mult_q,
  output logic [RATIO_W-1:0]          divr_q,
  output logic [PS_W-1:0]             presc_q,
  output logic                        presc_wr
);
  import fbaud_pkg::*;

  logic hit_ps, hit_mu, hit_dv;
  logic [RATIO_W-1:0] mult_d, divr_d;
  logic [PS_W-1:0]    presc_d;

  assign hit_ps   = (bus_addr == OFS_PRESC);
  assign hit_mu   = (bus_addr == OFS_MULT);
  assign hit_dv   = (bus_addr == OFS_DIVR);
  assign presc_wr = bus_wr & hit_ps;

  always_comb begin
    mult_d  = mult_q;
    divr_d  = divr_q;
    presc_d = presc_q;
    if (bus_wr && hit_mu) mult_d  = bus_wdata;
    if (bus_wr && hit_dv) divr_d  = bus_wdata;
    if (presc_wr)         presc_d = bus_wdata[PS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q  <= RATIO_W'(RST_MULT);
      divr_q  <= RATIO_W'(RST_DIVR);
      presc_q <= PS_W'(RST_PRESC);
    end else begin
      mult_q  <= mult_d;
      divr_q  <= divr_d;
      presc_q <= presc_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ps) bus_rdata = RATIO_W'(presc_q);
    if (hit_mu) bus_rdata = mult_q;
    if (hit_dv) bus_rdata = divr_q;
  end

  AST_PS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    presc_wr |=> presc_q == $past(bus_wdata[PS_W-1:0])) else $error("ps write"); // R2
  AST_MULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_mu) |=> $stable(mult_q)) else $error("mult hold"); // R2
endmodule

// File: rtl/fbaud_ratio.sv
module fbaud_ratio #(
  parameter int unsigned RATIO_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] mult,
  input  logic [RATIO_W-1:0] divr,
  output logic               os_tick
);
  localparam int unsigned SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] acc_q, acc_d;
  logic               tick_d;
  logic               legal;
  logic [SUM_W-1:0]   sum;
  logic [SUM_W-1:0]   sum_wrap;

  assign legal    = (divr != '0) && (mult <= divr);
  assign sum      = {1'b0, acc_q} + {1'b0, mult};
  assign sum_wrap = sum - {1'b0, divr};

  always_comb begin
    acc_d  = '0;
    tick_d = 1'b0;
    if (legal) begin
      if (sum >= {1'b0, divr}) begin
        acc_d  = sum_wrap[RATIO_W-1:0];
        tick_d = 1'b1;
      end else begin
        acc_d  = sum[RATIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      os_tick <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      os_tick <= tick_d;
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> (!os_tick && acc_q == '0)) else $error("illegal ratio active"); // R5
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && mult == divr) |=> os_tick) else $error("full rate missed"); // R4
endmodule

// File: rtl/fbaud_presc.sv
module fbaud_presc #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] presc,
  input  logic            reload,
  input  logic            os_tick,
  output logic            baud_tick
);
  logic [PS_W-1:0] cnt_q, cnt_d;
  logic [PS_W-1:0] last;
  logic            baud_d;

  assign last = (presc == '0) ? '0 : presc - PS_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    baud_d = 1'b0;
    if (reload) begin
      cnt_d = '0;
    end else if (os_tick) begin
      if (cnt_q >= last) begin
        cnt_d  = '0;
        baud_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + PS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      baud_tick <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      baud_tick <= baud_d;
    end
  end

  AST_BAUD_AFTER_OS: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(os_tick)) else $error("baud without os"); // R9
  AST_UNIT_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    (presc <= PS_W'(1) && os_tick && !reload) |=> baud_tick) else $error("unit prescale"); // R7
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !baud_tick) else $error("reload pulse"); // R8
endmodule

// File: rtl/fbaud_gen.sv
module fbaud_gen #(
  parameter int unsigned RATIO_W = 24,
  parameter int unsigned PS_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [fbaud_pkg::ADDR_W-1:0] bus_addr,
  input  logic [RATIO_W-1:0]           bus_wdata,
  output logic [RATIO_W-1:0]           bus_rdata,
  output logic                         os_tick,
  output logic                         baud_tick
);
  logic [1:0]         rst_sync;
  logic               rst_ns;
  logic [RATIO_W-1:0] mult_q, divr_q;
  logic [PS_W-1:0]    presc_q;
  logic               presc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  fbaud_regs #(.RATIO_W(RATIO_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mult_q(mult_q),
    .divr_q(divr_q), .presc_q(presc_q), .presc_wr(presc_wr)
  );

  fbaud_ratio #(.RATIO_W(RATIO_W)) u_ratio (
    .clk(clk), .rst_n(rst_ns), .mult(mult_q), .divr(divr_q), .os_tick(os_tick)
  );

  fbaud_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_ns), .presc(presc_q), .reload(presc_wr),
    .os_tick(os_tick), .baud_tick(baud_tick)
  );

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    $rose(rst_ns) |-> (mult_q == RATIO_W'(1) && divr_q == RATIO_W'(1) && presc_q == PS_W'(16)))
    else $error("reset defaults"); // R1
endmodule

// File: tb/tb_fbaud_gen.sv
module tb_fbaud_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [23:0] bus_wdata;
  logic [23:0] bus_rdata;
  logic        os_tick, baud_tick;
  int          errors = 0;
  int          checks = 0;

  localparam logic [7:0] A_PS = 8'h30, A_MU = 8'h34, A_DV = 8'h38;

  always #10 clk = ~clk;

  fbaud_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .os_tick(os_tick), .baud_tick(baud_tick)
  );

  function automatic longint exp_os(longint n, longint m, longint d);
    return (n * m) / d;
  endfunction

  function automatic longint exp_baud(longint os, longint ps);
    return os / ((ps == 0) ? 1 : ps);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [23:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [23:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Count os over the n cycles after the last write edge, baud shifted by one.
  task automatic measure(int n, output longint nos, output longint nbd);
    nos = 0; nbd = 0;
    for (int i = 1; i <= n + 1; i++) begin
      @(negedge clk);
      if (i <= n && os_tick)   nos++;
      if (i >= 2 && baud_tick) nbd++;
    end
  endtask

  task automatic run_case(string req, int ps, int m, int d, int n);
    longint nos, nbd, eo;
    wr(A_DV, 24'd0);
    wr(A_MU, m[23:0]);
    wr(A_PS, ps[23:0]);
    wr(A_DV, d[23:0]);
    measure(n, nos, nbd);
    eo = exp_os(n, m, d);
    check({req, " os count"}, nos, eo);
    check({req, " baud count"}, nbd, exp_baud(eo, ps));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] r;
    longint nos, nbd;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset defaults
    rd(A_MU, r); check("R1 mult", r, 1);
    rd(A_DV, r); check("R1 divr", r, 1);
    rd(A_PS, r); check("R1 presc", r, 16);

    // R2 decode: stray writes ignored, unmapped read zero
    wr(8'h3C, 24'h00ABCD);
    wr(8'h31, 24'h000055);
    wr(8'h00, 24'h123456);
    rd(A_MU, r); check("R2 mult kept", r, 1);
    rd(A_DV, r); check("R2 divr kept", r, 1);
    rd(A_PS, r); check("R2 presc kept", r, 16);
    rd(8'h3C, r); check("R2 unmapped read", r, 0);
    wr(A_PS, 24'hFFFF07);
    rd(A_PS, r); check("R2 presc low byte", r, 7);
    wr(A_MU, 24'hFFFFFF);
    rd(A_MU, r); check("R2 mult 24 bit", r, 24'hFFFFFF);

    // R4 full rate, R6 prescale by 16
    run_case("R4", 16, 1, 1, 400);
    run_case("R4 max", 16, 24'hFFFFFF, 24'hFFFFFF, 320);
    // R7 zero and unit prescaler
    run_case("R7 ps0", 0, 3, 7, 700);
    run_case("R7 ps1", 1, 5, 13, 520);
    // R3/R6 fixed fractions
    run_case("R3", 4, 1, 3, 900);
    run_case("R6", 16, 1152, 4096, 2000);

    // R5 illegal ratios
    wr(A_MU, 24'd10); wr(A_DV, 24'd5);
    measure(100, nos, nbd);
    check("R5 m>d os", nos, 0);
    check("R5 m>d baud", nbd, 0);
    wr(A_MU, 24'd1); wr(A_DV, 24'd0);
    measure(100, nos, nbd);
    check("R5 d=0 os", nos, 0);
    check("R5 d=0 baud", nbd, 0);

    // R8 prescaler restart, os every cycle
    wr(A_MU, 24'd1); wr(A_DV, 24'd1); wr(A_PS, 24'd4);
    repeat (6) @(negedge clk);
    wr(A_PS, 24'd4);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R8 restart phase", baud_tick, (i == 4) ? 1 : 0);
    end
    // R9 single-cycle pulse
    @(negedge clk);
    check("R9 one cycle", baud_tick, 0);

    // R3/R6 constrained random
    for (int k = 0; k < 20; k++) begin
      int d, m, ps;
      d  = int'($urandom % 32'hFFFFFF) + 1;
      m  = int'($urandom % d) + 1;
      ps = int'($urandom % 21);
      run_case("R3 random", ps, m, d, 600);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule